// File: doc/BRIEF.md
# Dual-Class Crossbar Scheduler for a Circuit-Switched Router

This block decides, every cycle, how the crossbar of a circuit-switched data-plane router is set up when two kinds of pre-arranged circuits share the router. These are reverse circuits and forward circuits. Each input port presents at most one candidate of each class. The reverse candidate is the reservation whose expected-use cycle is earliest. The forward candidate is the head of that port's in-order forward queue. Each input candidate names the output port it wants. Each output port states separately whether it holds a reverse candidate and whether it holds a forward candidate.

The block builds two input-to-output matchings side by side, one for each class. It then merges them into a single crossbar configuration. Every pair of the class that currently has precedence is kept. A pair of the other class is added only where both its input and its output are still free. The class with precedence swaps after every cycle in which both matchings were non-empty.

The result is registered one cycle after the inputs. It gives, for each output, an enable, the selected input and the class of the circuit. For each input it gives a one-cycle dequeue pulse on the virtual channel of the matched class. Reservation storage and flit buffering sit outside this block.

Top module: `xbar_dual_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero. The reverse class holds precedence first.
- R2: A pair (input i, output o) of one class forms only if three things hold. Input i has a valid candidate of that class, the candidate names o, and output o has a candidate of that same class. A candidate of the other class at o does not count.
- R3: When several inputs of one class name the same ready output, the lowest-numbered input wins that output for that class.
- R4: A destination index of NPORT or above never forms a pair.
- R5: In the merge, every pair of the precedence class is kept. A pair of the other class is kept only when neither its input nor its output is used by a kept pair.
- R6: Precedence swaps after a cycle in which both class matchings held at least one pair. It is unchanged otherwise. Encoding: `xbar_fwd[o]`=0 means reverse, 1 means forward.
- R7: Outputs are registered. The inputs sampled at a rising edge determine `xbar_en`, `xbar_sel`, `xbar_fwd`, `rev_deq` and `fwd_deq` from that edge until the next one. A dequeue pulse lasts one cycle unless the inputs persist. A disabled output drives select 0.
- R8: An input dequeues at most one class per cycle. The number of dequeue pulses equals the number of enabled outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev_req_vld | input | NPORT | Input i has a reverse candidate |
| rev_req_dst | input | NPORT*SW | Output named by each reverse candidate (SW = clog2(NPORT)) |
| fwd_req_vld | input | NPORT | Input i has a forward-queue head |
| fwd_req_dst | input | NPORT*SW | Output named by each forward head |
| rev_out_rdy | input | NPORT | Output o holds a reverse candidate |
| fwd_out_rdy | input | NPORT | Output o holds a forward candidate |
| xbar_en | output | NPORT | Output o is connected this cycle |
| xbar_sel | output | NPORT*SW | Input connected to output o |
| xbar_fwd | output | NPORT | Class of the circuit on output o (1 = forward) |
| rev_deq | output | NPORT | Dequeue pulse for input i, reverse channel |
| fwd_deq | output | NPORT | Dequeue pulse for input i, forward channel |

## Verification
The bench sets up an input conflict and an output conflict in the same cycle, first under reverse precedence and then under forward precedence. A merge that ignored the input check would connect one input to two outputs. A merge that ignored precedence would keep the wrong class on the shared output. A forward-only cycle placed between two conflicts exposes a precedence register that swaps on every busy cycle. Readiness of the wrong class, out-of-range destinations and three-way contention for one output test whether pairs form only under the stated rules and whether the lowest input wins.

// File: rtl/xds_pkg.sv
package xds_pkg;
    typedef enum logic {
        CLS_REV = 1'b0,
        CLS_FWD = 1'b1
    } cls_e;

    localparam int NCLS = 2;
endpackage

// File: rtl/xds_class_match.sv
// Single-class matcher: each output takes the lowest-numbered input that
// names it, provided the output holds a candidate of this class.
module xds_class_match #(
    parameter int NPORT = 5,
    parameter int SW    = $clog2(NPORT)
) (
    input  logic [NPORT-1:0]         req_vld,
    input  logic [NPORT-1:0][SW-1:0] req_dst,
    input  logic [NPORT-1:0]         out_rdy,
    output logic [NPORT-1:0]         gnt_vld,
    output logic [NPORT-1:0][SW-1:0] gnt_src
);
    always_comb begin
        gnt_vld = '0;
        gnt_src = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = NPORT - 1; i >= 0; i--) begin
                if (out_rdy[o] && req_vld[i] && (req_dst[i] == SW'(o))) begin
                    gnt_vld[o] = 1'b1;
                    gnt_src[o] = SW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/xds_merge.sv
// Combines the two class matchings; the precedence class goes first.
module xds_merge #(
    parameter int NPORT = 5,
    parameter int SW    = $clog2(NPORT),
    parameter int NCLS  = 2
) (
    input  logic                               prio_fwd,
    input  logic [NCLS-1:0][NPORT-1:0]         gnt_vld,
    input  logic [NCLS-1:0][NPORT-1:0][SW-1:0] gnt_src,
    output logic [NPORT-1:0]                   out_en,
    output logic [NPORT-1:0][SW-1:0]           out_sel,
    output logic [NPORT-1:0]                   out_fwd,
    output logic [NCLS-1:0][NPORT-1:0]         deq,
    output logic                               both_busy
);
    logic             pri_c;
    logic             sec_c;
    logic [NPORT-1:0] in_used;

    assign pri_c     = prio_fwd;
    assign sec_c     = ~prio_fwd;
    assign both_busy = (|gnt_vld[0]) && (|gnt_vld[1]);

    always_comb begin
        in_used = '0;
        out_en  = '0;
        out_sel = '0;
        out_fwd = '0;
        deq     = '0;
        for (int o = 0; o < NPORT; o++) begin
            if (gnt_vld[pri_c][o]) begin
                out_en[o]                    = 1'b1;
                out_sel[o]                   = gnt_src[pri_c][o];
                out_fwd[o]                   = pri_c;
                in_used[gnt_src[pri_c][o]]   = 1'b1;
                deq[pri_c][gnt_src[pri_c][o]] = 1'b1;
            end
        end
        for (int o = 0; o < NPORT; o++) begin
            if (!out_en[o] && gnt_vld[sec_c][o] && !in_used[gnt_src[sec_c][o]]) begin
                out_en[o]                     = 1'b1;
                out_sel[o]                    = gnt_src[sec_c][o];
                out_fwd[o]                    = sec_c;
                in_used[gnt_src[sec_c][o]]    = 1'b1;
                deq[sec_c][gnt_src[sec_c][o]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_dual_sched.sv
module xbar_dual_sched #(
    parameter int NPORT = 5,
    localparam int SW   = $clog2(NPORT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         rev_req_vld,
    input  logic [NPORT-1:0][SW-1:0] rev_req_dst,
    input  logic [NPORT-1:0]         fwd_req_vld,
    input  logic [NPORT-1:0][SW-1:0] fwd_req_dst,
    input  logic [NPORT-1:0]         rev_out_rdy,
    input  logic [NPORT-1:0]         fwd_out_rdy,
    output logic [NPORT-1:0]         xbar_en,
    output logic [NPORT-1:0][SW-1:0] xbar_sel,
    output logic [NPORT-1:0]         xbar_fwd,
    output logic [NPORT-1:0]         rev_deq,
    output logic [NPORT-1:0]         fwd_deq
);
    import xds_pkg::*;

    typedef struct packed {
        logic                     prio_fwd;
        logic [NPORT-1:0]         en;
        logic [NPORT-1:0][SW-1:0] sel;
        logic [NPORT-1:0]         fwd;
        logic [NPORT-1:0]         rdeq;
        logic [NPORT-1:0]         fdeq;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [NCLS-1:0][NPORT-1:0]         cls_vld;
    logic [NCLS-1:0][NPORT-1:0][SW-1:0] cls_dst;
    logic [NCLS-1:0][NPORT-1:0]         cls_rdy;
    logic [NCLS-1:0][NPORT-1:0]         gnt_vld;
    logic [NCLS-1:0][NPORT-1:0][SW-1:0] gnt_src;

    logic [NPORT-1:0]           mrg_en;
    logic [NPORT-1:0][SW-1:0]   mrg_sel;
    logic [NPORT-1:0]           mrg_fwd;
    logic [NCLS-1:0][NPORT-1:0] mrg_deq;
    logic                       mrg_both;

    assign cls_vld[CLS_REV] = rev_req_vld;
    assign cls_dst[CLS_REV] = rev_req_dst;
    assign cls_rdy[CLS_REV] = rev_out_rdy;
    assign cls_vld[CLS_FWD] = fwd_req_vld;
    assign cls_dst[CLS_FWD] = fwd_req_dst;
    assign cls_rdy[CLS_FWD] = fwd_out_rdy;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        xds_class_match #(.NPORT(NPORT), .SW(SW)) u_match (
            .req_vld (cls_vld[c]),
            .req_dst (cls_dst[c]),
            .out_rdy (cls_rdy[c]),
            .gnt_vld (gnt_vld[c]),
            .gnt_src (gnt_src[c])
        );
    end

    xds_merge #(.NPORT(NPORT), .SW(SW), .NCLS(NCLS)) u_merge (
        .prio_fwd  (st_q.prio_fwd),
        .gnt_vld   (gnt_vld),
        .gnt_src   (gnt_src),
        .out_en    (mrg_en),
        .out_sel   (mrg_sel),
        .out_fwd   (mrg_fwd),
        .deq       (mrg_deq),
        .both_busy (mrg_both)
    );

    always_comb begin
        st_d          = st_q;
        st_d.prio_fwd = st_q.prio_fwd ^ mrg_both;
        st_d.en       = mrg_en;
        st_d.sel      = mrg_sel;
        st_d.fwd      = mrg_fwd;
        st_d.rdeq     = mrg_deq[CLS_REV];
        st_d.fdeq     = mrg_deq[CLS_FWD];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xbar_en  = st_q.en;
    assign xbar_sel = st_q.sel;
    assign xbar_fwd = st_q.fwd;
    assign rev_deq  = st_q.rdeq;
    assign fwd_deq  = st_q.fdeq;
endmodule

// File: rtl/xbar_dual_sched_chk.sv
module xbar_dual_sched_chk #(
    parameter int NPORT = 5,
    localparam int SW   = $clog2(NPORT)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NPORT-1:0]         rev_req_vld,
    input logic [NPORT-1:0][SW-1:0] rev_req_dst,
    input logic [NPORT-1:0]         fwd_req_vld,
    input logic [NPORT-1:0][SW-1:0] fwd_req_dst,
    input logic [NPORT-1:0]         rev_out_rdy,
    input logic [NPORT-1:0]         fwd_out_rdy,
    input logic [NPORT-1:0]         xbar_en,
    input logic [NPORT-1:0][SW-1:0] xbar_sel,
    input logic [NPORT-1:0]         xbar_fwd,
    input logic [NPORT-1:0]         rev_deq,
    input logic [NPORT-1:0]         fwd_deq
);
    logic [NPORT-1:0]         p_rv, p_fv, p_rr, p_fr;
    logic [NPORT-1:0][SW-1:0] p_rd, p_fd;
    logic [NPORT-1:0]         lower_rev, lower_fwd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_rv <= '0; p_fv <= '0; p_rr <= '0; p_fr <= '0;
            p_rd <= '0; p_fd <= '0;
        end else begin
            p_rv <= rev_req_vld; p_fv <= fwd_req_vld;
            p_rr <= rev_out_rdy; p_fr <= fwd_out_rdy;
            p_rd <= rev_req_dst; p_fd <= fwd_req_dst;
        end
    end

    always_comb begin
        lower_rev = '0;
        lower_fwd = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int j = 0; j < NPORT; j++) begin
                if (SW'(j) < xbar_sel[o]) begin
                    if (p_rv[j] && p_rd[j] == SW'(o)) lower_rev[o] = 1'b1;
                    if (p_fv[j] && p_fd[j] == SW'(o)) lower_fwd[o] = 1'b1;
                end
            end
        end
    end

    a_r8_single_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_deq & fwd_deq) == '0);

    a_r8_deq_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rev_deq | fwd_deq) == $countones(xbar_en));

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        a_r2_rev_backed: assert property (@(posedge clk) disable iff (!rst_n)
            (xbar_en[o] && !xbar_fwd[o]) |->
                (p_rr[o] && p_rv[xbar_sel[o]] && p_rd[xbar_sel[o]] == SW'(o) && rev_deq[xbar_sel[o]]));

        a_r2_fwd_backed: assert property (@(posedge clk) disable iff (!rst_n)
            (xbar_en[o] && xbar_fwd[o]) |->
                (p_fr[o] && p_fv[xbar_sel[o]] && p_fd[xbar_sel[o]] == SW'(o) && fwd_deq[xbar_sel[o]]));

        a_r3_lowest_rev: assert property (@(posedge clk) disable iff (!rst_n)
            (xbar_en[o] && !xbar_fwd[o]) |-> !lower_rev[o]);

        a_r3_lowest_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            (xbar_en[o] && xbar_fwd[o]) |-> !lower_fwd[o]);

        a_r4_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
            xbar_en[o] |-> (int'(xbar_sel[o]) < NPORT));

        a_r7_idle_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !xbar_en[o] |-> (xbar_sel[o] == '0 && !xbar_fwd[o]));
    end
endmodule

bind xbar_dual_sched xbar_dual_sched_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/xbar_dual_sched_test.sv
`timescale 1ns/1ps
module xbar_dual_sched_test;
    localparam int NP = 5;
    localparam int SW = $clog2(NP);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NP-1:0]         rev_req_vld, fwd_req_vld, rev_out_rdy, fwd_out_rdy;
    logic [NP-1:0][SW-1:0] rev_req_dst, fwd_req_dst;
    logic [NP-1:0]         xbar_en, xbar_fwd, rev_deq, fwd_deq;
    logic [NP-1:0][SW-1:0] xbar_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [NP-1:0][SW-1:0] es;

    always #10 clk = ~clk;

    xbar_dual_sched #(.NPORT(NP)) uut (.*);

    task automatic clr();
        rev_req_vld = '0; fwd_req_vld = '0;
        rev_req_dst = '0; fwd_req_dst = '0;
        rev_out_rdy = '0; fwd_out_rdy = '0;
        es = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(string tag, logic [NP-1:0] en, logic [NP-1:0] fw,
                              logic [NP-1:0] rd, logic [NP-1:0] fd);
        chk({tag, " en"},      32'(xbar_en),  32'(en));
        chk({tag, " sel"},     32'(xbar_sel), 32'(es));
        chk({tag, " class"},   32'(xbar_fwd), 32'(fw));
        chk({tag, " rev_deq"}, 32'(rev_deq),  32'(rd));
        chk({tag, " fwd_deq"}, 32'(fwd_deq),  32'(fd));
    endtask

    task automatic t_reset();
        es = '0;
        expect_out("R1 reset", '0, '0, '0, '0);
    endtask

    task automatic t_rev_only();
        clr();
        rev_req_vld = 5'b01001; rev_req_dst[0] = 3'd2; rev_req_dst[3] = 3'd4;
        rev_out_rdy = 5'b10100;
        tick();
        es[2] = 3'd0; es[4] = 3'd3;
        expect_out("R2 R7 reverse pairs", 5'b10100, 5'b00000, 5'b01001, 5'b00000);
    endtask

    task automatic t_wrong_class_ready();
        clr();
        rev_req_vld[1] = 1'b1; rev_req_dst[1] = 3'd1; fwd_out_rdy[1] = 1'b1;
        fwd_req_vld[2] = 1'b1; fwd_req_dst[2] = 3'd0; rev_out_rdy[0] = 1'b1;
        tick();
        expect_out("R2 other-class ready ignored", '0, '0, '0, '0);
    endtask

    task automatic t_contention();
        clr();
        rev_req_vld = 5'b10110;
        rev_req_dst[1] = 3'd3; rev_req_dst[2] = 3'd3; rev_req_dst[4] = 3'd3;
        rev_out_rdy[3] = 1'b1;
        tick();
        es[3] = 3'd1;
        expect_out("R3 lowest input wins", 5'b01000, '0, 5'b00010, '0);
    endtask

    task automatic t_bad_dst();
        clr();
        rev_req_vld = 5'b00011; rev_req_dst[0] = 3'd5; rev_req_dst[1] = 3'd7;
        fwd_req_vld[2] = 1'b1;  fwd_req_dst[2] = 3'd6;
        rev_out_rdy = '1; fwd_out_rdy = '1;
        tick();
        expect_out("R4 out-of-range dst", '0, '0, '0, '0);
    endtask

    task automatic load_conflict();
        clr();
        rev_req_vld[0] = 1'b1; rev_req_dst[0] = 3'd1;
        fwd_req_vld = 5'b11001;
        fwd_req_dst[0] = 3'd2; fwd_req_dst[3] = 3'd1; fwd_req_dst[4] = 3'd4;
        rev_out_rdy[1] = 1'b1;
        fwd_out_rdy = 5'b10110;
    endtask

    task automatic t_merge_rev_first();
        load_conflict();
        tick();
        es[1] = 3'd0; es[4] = 3'd4;
        expect_out("R5 reverse precedence", 5'b10010, 5'b10000, 5'b00001, 5'b10000);
    endtask

    task automatic t_merge_fwd_first();
        load_conflict();
        tick();
        es[1] = 3'd3; es[2] = 3'd0; es[4] = 3'd4;
        expect_out("R5 R6 forward precedence after swap", 5'b10110, 5'b10110, 5'b00000, 5'b11001);
    endtask

    task automatic t_no_swap_single_class();
        clr();
        fwd_req_vld[2] = 1'b1; fwd_req_dst[2] = 3'd0; fwd_out_rdy[0] = 1'b1;
        tick();
        es[0] = 3'd2;
        expect_out("R6 forward-only cycle", 5'b00001, 5'b00001, 5'b00000, 5'b00100);
        clr();
        rev_req_vld[2] = 1'b1; rev_req_dst[2] = 3'd0;
        fwd_req_vld[1] = 1'b1; fwd_req_dst[1] = 3'd0;
        rev_out_rdy[0] = 1'b1; fwd_out_rdy[0] = 1'b1;
        tick();
        es[0] = 3'd2;
        expect_out("R6 no swap after single-class cycle", 5'b00001, 5'b00000, 5'b00100, 5'b00000);
        tick();
        es[0] = 3'd1;
        expect_out("R6 swap after both-busy cycle", 5'b00001, 5'b00001, 5'b00000, 5'b00010);
    endtask

    task automatic t_pulse_ends();
        clr();
        tick();
        expect_out("R7 pulse ends when inputs drop", '0, '0, '0, '0);
    endtask

    task automatic t_full_perm();
        clr();
        rev_req_vld = '1; rev_out_rdy = '1;
        for (int i = 0; i < NP; i++) rev_req_dst[i] = SW'((i + 1) % NP);
        tick();
        for (int o = 0; o < NP; o++) es[o] = SW'((o + NP - 1) % NP);
        expect_out("R8 full permutation", '1, '0, '1, '0);
        chk("R8 one VC per input", 32'(rev_deq & fwd_deq), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_rev_only();
        t_wrong_class_ready();
        t_contention();
        t_bad_dst();
        t_merge_rev_first();
        t_merge_fwd_first();
        t_no_swap_single_class();
        t_pulse_ends();
        t_full_perm();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule